// File: doc/BRIEF.md
# Floating-point error reporting controller

This block sits between a floating-point execution unit and the integer core. It decides how an unmasked floating-point exception is reported to the rest of the machine. A one-bit reporting-mode register selects between two methods. In native mode, each reported error becomes a one-cycle request for exception vector 16 to the core. In external mode, an active-low error pin is driven for board logic, and an active-low ignore-error input decides whether the next floating-point instruction may proceed or must be held.

The time at which an error is reported depends on the exception and on the instruction that raised it. A store, or one of the three core exceptions (invalid operation, denormal operand, stack fault) raised by an instruction from the early-report group, is reported at once. Every other unmasked exception is parked in a sticky pending state. It is reported only when the next floating-point instruction starts. The error stays latched until a clear-exceptions strobe arrives.

The controller is a four-state machine. `ST_IDLE` means no error is held. `ST_PEND` means an error is held but not yet reported. `ST_REPORT` means the error is reported. `ST_FREEZE` means the error is reported and the next instruction is stalled. The named transitions are:

- IDLE→REPORT: immediate event.
- IDLE→PEND: deferred event.
- PEND→REPORT: start strobe in native mode, start strobe with ignore asserted, or a later immediate event.
- PEND→FREEZE: start strobe in external mode with ignore deasserted.
- REPORT→FREEZE: start strobe in external mode with ignore deasserted.
- FREEZE→REPORT: ignore asserted.
- any state→IDLE: clear strobe.

Top module: `fperr_report_ctrl`

## Requirements
- R1: The mode bit resets to 0 (external reporting). A write with `mode_we`=1 loads `mode_wdata`, and the new value governs behaviour from the next cycle on.
- R2: In native mode (mode=1), `err_n` stays 1 and `fp_freeze` is never entered. `exc_req` pulses high for exactly the cycle after each report condition: an immediate event, or a start strobe while an error is pending.
- R3: Exception kinds invalid (0), denormal (1) and stack fault (6) raised by instruction kinds 5 to 12 are reported in the cycle after the event. Kinds 5 to 12 are transcendental, integer arithmetic, square root, scale, partial remainder, extract, BCD load and BCD store-and-pop. Other exception kinds on those instructions are deferred.
- R4: Any exception kind raised by a store (instruction kind 3 = float store, 4 = integer store, 12 = BCD store-and-pop) is reported in the cycle after the event.
- R5: Every other unmasked exception sets the pending state with no output change. It is reported in the cycle after the next `fp_start` strobe.
- R6: An event with `exc_masked`=1 changes no output and no state.
- R7: In external mode, an `fp_start` strobe while an error is pending or reported with `ignore_n`=1 raises `fp_freeze` (and `err_n`=0) from the next cycle. The freeze holds until `ignore_n`=0, which releases it in the next cycle while `err_n` stays 0.
- R8: In external mode, an `fp_start` strobe with `ignore_n`=0 lets the instruction proceed: `fp_freeze` stays 0 and `err_n` becomes or stays 0.
- R9: `clr_exc` returns the block to idle from any state: from the next cycle, `err_n`=1 and `fp_freeze`=0. An event in the same cycle as the clear is evaluated after the clear.
- R10: An immediate-class event arriving while an error is pending reports it in the next cycle.
- R11: A reported error stays reported (sticky) for any number of cycles, and across mode changes, until `clr_exc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Load strobe for the reporting-mode bit |
| mode_wdata | input | 1 | New mode value: 1 native, 0 external |
| exc_valid | input | 1 | Exception event strobe from the execution unit |
| exc_masked | input | 1 | The event's exception is masked |
| exc_kind | input | EXC_W | Exception kind code |
| insn_kind | input | INSN_W | Class of the instruction that raised the event |
| fp_start | input | 1 | Next floating-point instruction starts |
| clr_exc | input | 1 | Clear-exceptions strobe |
| ignore_n | input | 1 | Active-low ignore-error input |
| err_n | output | 1 | Active-low error pin (external mode) |
| exc_req | output | 1 | One-cycle vector-16 exception request (native mode) |
| fp_freeze | output | 1 | Stall for the next floating-point instruction |

## Verification
The bench builds the block with its default widths: 3-bit exception kinds, 4-bit instruction classes, and the default early-report, store and core-exception masks. With these widths every code of both fields can be driven directly. The stimulus can therefore place the same exception on an early-report instruction, a store and a plain arithmetic instruction, and show each of the three reporting times. It can also place a non-core exception on an early-report instruction and show that this case is deferred.

// File: rtl/fperr_pkg.sv
package fperr_pkg;

    localparam int EXC_W_DEF  = 3;
    localparam int INSN_W_DEF = 4;

    // instruction classes 5..12 report core exceptions at once
    localparam logic [15:0] EARLY_INSN_DEF = 16'h1FE0;
    // float store (3), integer store (4), BCD store-and-pop (12)
    localparam logic [15:0] STORE_INSN_DEF = 16'h1018;
    // invalid (0), denormal (1), stack fault (6)
    localparam logic [7:0]  CORE_EXC_DEF   = 8'h43;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_REPORT = 2'd2,
        ST_FREEZE = 2'd3
    } fperr_state_e;

endpackage

// File: rtl/fperr_classify.sv
module fperr_classify #(
    parameter int EXC_W  = 3,
    parameter int INSN_W = 4,
    parameter logic [(1<<INSN_W)-1:0] EARLY_MASK = '0,
    parameter logic [(1<<INSN_W)-1:0] STORE_MASK = '0,
    parameter logic [(1<<EXC_W)-1:0]  CORE_MASK  = '0
) (
    input  logic [EXC_W-1:0]  exc_kind_i,
    input  logic [INSN_W-1:0] insn_kind_i,
    output logic              report_now_o
);

    localparam int N_INSN = 1 << INSN_W;
    localparam int N_EXC  = 1 << EXC_W;

    logic [N_INSN-1:0] early_hit;
    logic [N_INSN-1:0] store_hit;
    logic [N_EXC-1:0]  core_hit;

    // one decode bit per instruction class, gated by the class masks
    for (genvar gi = 0; gi < N_INSN; gi++) begin : g_insn
        assign early_hit[gi] = EARLY_MASK[gi] && (insn_kind_i == INSN_W'(gi));
        assign store_hit[gi] = STORE_MASK[gi] && (insn_kind_i == INSN_W'(gi));
    end

    // one decode bit per exception kind
    for (genvar ge = 0; ge < N_EXC; ge++) begin : g_exc
        assign core_hit[ge] = CORE_MASK[ge] && (exc_kind_i == EXC_W'(ge));
    end

    assign report_now_o = (|store_hit) || ((|early_hit) && (|core_hit));

endmodule

// File: rtl/fperr_mode_reg.sv
module fperr_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic wdata_i,
    output logic native_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            native_o <= 1'b0;
        end else if (we_i) begin
            native_o <= wdata_i;
        end
    end

    a_r1_mode_load : assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (native_o == $past(wdata_i)));

    a_r1_mode_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(native_o));

endmodule

// File: rtl/fperr_fsm.sv
module fperr_fsm
    import fperr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic native_i,
    input  logic accept_i,
    input  logic report_now_i,
    input  logic fp_start_i,
    input  logic ignore_n_i,
    input  logic clr_i,
    output logic err_n_o,
    output logic freeze_o,
    output logic req_o
);

    fperr_state_e state_q, state_d, base;
    logic         req_d;

    // next-state decision: the clear is applied first, then the cycle's events
    always_comb begin
        base    = clr_i ? ST_IDLE : state_q;
        state_d = base;
        req_d   = 1'b0;
        unique case (base)
            ST_IDLE: begin
                if (accept_i) begin
                    if (report_now_i) begin
                        state_d = ST_REPORT;
                        req_d   = native_i;
                    end else begin
                        state_d = ST_PEND;
                    end
                end
            end
            ST_PEND: begin
                if (fp_start_i) begin
                    if (!native_i && ignore_n_i) begin
                        state_d = ST_FREEZE;
                    end else begin
                        state_d = ST_REPORT;
                        req_d   = native_i;
                    end
                end else if (accept_i && report_now_i) begin
                    state_d = ST_REPORT;
                    req_d   = native_i;
                end
            end
            ST_REPORT: begin
                if (fp_start_i && !native_i && ignore_n_i) begin
                    state_d = ST_FREEZE;
                end
            end
            ST_FREEZE: begin
                if (!ignore_n_i) begin
                    state_d = ST_REPORT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and registered request pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            req_o   <= req_d;
        end
    end

    // output decode from held state and mode
    always_comb begin
        err_n_o  = 1'b1;
        freeze_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PEND: begin
                err_n_o  = 1'b1;
                freeze_o = 1'b0;
            end
            ST_REPORT: begin
                err_n_o  = native_i;
                freeze_o = 1'b0;
            end
            ST_FREEZE: begin
                err_n_o  = native_i;
                freeze_o = 1'b1;
            end
            default: begin
                err_n_o  = 1'b1;
                freeze_o = 1'b0;
            end
        endcase
    end

    a_r6_masked_idle : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !accept_i && !clr_i) |=> (state_q == ST_IDLE));

    a_r5_defer : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && accept_i && !report_now_i && !clr_i) |=> (state_q == ST_PEND));

    a_r9_clear : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !accept_i) |=> (state_q == ST_IDLE && !req_o));

    a_r2_req_native : assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(native_i));

    a_r2_no_native_freeze : assert property (@(posedge clk) disable iff (!rst_n)
        (native_i && state_q != ST_FREEZE) |=> (state_q != ST_FREEZE));

    a_r7_release : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREEZE && !ignore_n_i && !clr_i) |=> (state_q == ST_REPORT));

    a_r11_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPORT && !clr_i) |=> (state_q == ST_REPORT || state_q == ST_FREEZE));

endmodule

// File: rtl/fperr_report_ctrl.sv
module fperr_report_ctrl
    import fperr_pkg::*;
#(
    parameter int EXC_W  = EXC_W_DEF,
    parameter int INSN_W = INSN_W_DEF,
    parameter logic [(1<<INSN_W)-1:0] EARLY_MASK = EARLY_INSN_DEF,
    parameter logic [(1<<INSN_W)-1:0] STORE_MASK = STORE_INSN_DEF,
    parameter logic [(1<<EXC_W)-1:0]  CORE_MASK  = CORE_EXC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic              mode_wdata,
    input  logic              exc_valid,
    input  logic              exc_masked,
    input  logic [EXC_W-1:0]  exc_kind,
    input  logic [INSN_W-1:0] insn_kind,
    input  logic              fp_start,
    input  logic              clr_exc,
    input  logic              ignore_n,
    output logic              err_n,
    output logic              exc_req,
    output logic              fp_freeze
);

    logic native_q;
    logic report_now;
    logic accept;

    assign accept = exc_valid && !exc_masked;

    fperr_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (mode_we),
        .wdata_i  (mode_wdata),
        .native_o (native_q)
    );

    fperr_classify #(
        .EXC_W      (EXC_W),
        .INSN_W     (INSN_W),
        .EARLY_MASK (EARLY_MASK),
        .STORE_MASK (STORE_MASK),
        .CORE_MASK  (CORE_MASK)
    ) u_class (
        .exc_kind_i   (exc_kind),
        .insn_kind_i  (insn_kind),
        .report_now_o (report_now)
    );

    fperr_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .native_i     (native_q),
        .accept_i     (accept),
        .report_now_i (report_now),
        .fp_start_i   (fp_start),
        .ignore_n_i   (ignore_n),
        .clr_i        (clr_exc),
        .err_n_o      (err_n),
        .freeze_o     (fp_freeze),
        .req_o        (exc_req)
    );

    a_r7_freeze_pin : assert property (@(posedge clk) disable iff (!rst_n)
        (fp_freeze && !native_q) |-> !err_n);

    a_r2_native_pin_quiet : assert property (@(posedge clk) disable iff (!rst_n)
        native_q |-> err_n);

    a_r6_masked_no_req : assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_masked && !fp_start && err_n && !fp_freeze && !native_q)
            |=> (err_n && !exc_req));

endmodule

// File: tb/fperr_report_ctrl_bench.sv
module fperr_report_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_we, mode_wdata, exc_valid, exc_masked;
    logic [2:0] exc_kind;
    logic [3:0] insn_kind;
    logic       fp_start, clr_exc, ignore_n;
    logic       err_n, exc_req, fp_freeze;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fperr_report_ctrl u_fperr_report_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .exc_valid(exc_valid), .exc_masked(exc_masked), .exc_kind(exc_kind),
        .insn_kind(insn_kind), .fp_start(fp_start), .clr_exc(clr_exc),
        .ignore_n(ignore_n), .err_n(err_n), .exc_req(exc_req), .fp_freeze(fp_freeze)
    );

    // fields: req | clr we wd | valid masked | ekind ikind | start ign | exp err_n req freeze
    function automatic logic [20:0] V(input int r, input int clr, input int we, input int wd,
                                      input int v, input int m, input int ek, input int ik,
                                      input int st, input int ign,
                                      input int ee, input int er, input int ef);
        return {4'(r), 1'(clr), 1'(we), 1'(wd), 1'(v), 1'(m), 3'(ek), 4'(ik),
                1'(st), 1'(ign), 1'(ee), 1'(er), 1'(ef)};
    endfunction

    localparam int NV = 31;
    localparam logic [20:0] VEC [NV] = '{
        V(3, 0,0,0, 1,0, 0, 5, 0,1, 0,0,0),  // R3 invalid on transcendental
        V(11,0,0,0, 0,0, 0, 0, 0,1, 0,0,0),  // R11 stays reported
        V(9, 1,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R9 clear
        V(5, 0,0,0, 1,0, 2, 0, 0,1, 1,0,0),  // R5 zero-divide on arith: pending
        V(5, 0,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R5 still quiet
        V(8, 0,0,0, 0,0, 0, 0, 1,0, 0,0,0),  // R8 start with ignore asserted
        V(7, 0,0,0, 0,0, 0, 0, 1,1, 0,0,1),  // R7 start with ignore deasserted
        V(7, 0,0,0, 0,0, 0, 0, 0,1, 0,0,1),  // R7 freeze held
        V(7, 0,0,0, 0,0, 0, 0, 0,0, 0,0,0),  // R7 release by ignore
        V(9, 1,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R9 clear
        V(6, 0,0,0, 1,1, 0, 5, 0,1, 1,0,0),  // R6 masked event
        V(4, 0,0,0, 1,0, 3, 4, 0,1, 0,0,0),  // R4 overflow on integer store
        V(9, 1,0,0, 1,0, 5, 3, 0,1, 0,0,0),  // R9 clear then precision on float store
        V(9, 1,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R9 clear
        V(10,0,0,0, 1,0, 4, 0, 0,1, 1,0,0),  // R10 underflow deferred
        V(10,0,0,0, 1,0, 6, 9, 0,1, 0,0,0),  // R10 stack fault on remainder promotes
        V(9, 1,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R9 clear
        V(5, 0,0,0, 1,0, 0, 0, 0,1, 1,0,0),  // R5 invalid on plain arith: pending
        V(7, 0,0,0, 0,0, 0, 0, 1,1, 0,0,1),  // R7 pending to freeze
        V(9, 1,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R9 clear from freeze
        V(1, 0,1,1, 0,0, 0, 0, 0,1, 1,0,0),  // R1 switch to native
        V(2, 0,0,0, 1,0, 1, 7, 0,1, 1,1,0),  // R2 denormal on sqrt: request
        V(2, 0,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R2 request lasts one cycle
        V(9, 1,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R9 clear
        V(5, 0,0,0, 1,0, 3, 1, 0,1, 1,0,0),  // R5 overflow on compare: pending
        V(5, 0,0,0, 0,0, 0, 0, 1,1, 1,1,0),  // R5 start reports, R2 no freeze
        V(2, 0,0,0, 0,0, 0, 0, 0,1, 1,0,0),  // R2 pulse ends
        V(6, 1,0,0, 1,1, 0, 5, 0,1, 1,0,0),  // R6 clear with masked event
        V(6, 0,0,0, 1,1, 6, 3, 0,1, 1,0,0),  // R6 masked store event
        V(1, 0,1,0, 0,0, 0, 0, 0,1, 1,0,0),  // R1 back to external
        V(3, 0,0,0, 1,0, 2, 5, 0,1, 1,0,0)   // R3 zero-divide on transcendental defers
    };

    task automatic check(input string tag, input logic [2:0] exp);
        n_checks++;
        if ({err_n, exc_req, fp_freeze} !== exp) begin
            n_fails++;
            $display("FAIL %s: got err_n/req/freeze=%b expected %b", tag,
                     {err_n, exc_req, fp_freeze}, exp);
        end
    endtask

    task automatic idle_in();
        mode_we = 0; mode_wdata = 0; exc_valid = 0; exc_masked = 0;
        exc_kind = 0; insn_kind = 0; fp_start = 0; clr_exc = 0; ignore_n = 1;
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check("R1 reset state", 3'b100);

        for (int i = 0; i < NV; i++) begin
            logic [20:0] w;
            w = VEC[i];
            clr_exc = w[16]; mode_we = w[15]; mode_wdata = w[14];
            exc_valid = w[13]; exc_masked = w[12]; exc_kind = w[11:9];
            insn_kind = w[8:5]; fp_start = w[4]; ignore_n = w[3];
            step();
            check($sformatf("R%0d vector %0d", w[20:17], i), w[2:0]);
        end

        // R1: default is external; reset in the middle of a report
        do_reset();
        exc_valid = 1; exc_kind = 6; insn_kind = 11;
        step(); idle_in();
        check("R1 default external immediate", 3'b000);
        rst_n = 0;
        step();
        check("R1 reset clears report", 3'b100);
        rst_n = 1;
        @(negedge clk);

        // R11: report survives mode flip and many cycles
        exc_valid = 1; exc_kind = 0; insn_kind = 3;
        step(); idle_in();
        mode_we = 1; mode_wdata = 1;
        step(); idle_in();
        check("R2 pin released in native", 3'b100);
        mode_we = 1; mode_wdata = 0;
        step(); idle_in();
        check("R11 report kept across mode flip", 3'b000);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 20; k++) begin
                step();
                if (err_n !== 1'b0) bad++;
            end
            n_checks++;
            if (bad != 0) begin
                n_fails++;
                $display("FAIL R11 sticky: %0d cycles released, expected 0", bad);
            end
        end
        clr_exc = 1;
        step(); idle_in();
        check("R9 final clear", 3'b100);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule